// File: doc/BRIEF.md
# Dual-Width Binary/Decimal Add-Subtract Unit

This unit performs add-with-carry, subtract-with-borrow and compare on a 16-bit accumulator value. A width select picks 8-bit or 16-bit operation. A decimal select picks plain binary or packed-BCD arithmetic, four bits per digit. Each accepted operation produces a new accumulator value and four condition flags: negative (N), overflow (V), zero (Z) and carry (C).

Operations arrive on a valid/ready input channel. Results leave on a valid/ready output channel, one clock cycle after the operation is accepted. `in_ready` is high when the output register is empty or is being drained in the same cycle, so a consumer that holds `out_ready` low stalls new operations. A result stays on the output, unchanged, until the consumer takes it.

The operation code `op_sel` has these encodings: 2'b00 adds, 2'b01 subtracts, and 2'b10 or 2'b11 compares. When `wide` is 1 the unit works on 16 bits. When `wide` is 0 it works on the low 8 bits only. When `bcd` is 1, add and subtract use decimal correction.

Top module: `bcd_addsub_unit`

## Requirements
- R1: `in_ready` equals `!out_valid || out_ready`. An operation is accepted when `in_valid && in_ready` at a rising edge, and its result appears with `out_valid` high after that same edge. While `out_valid && !out_ready`, the outputs hold their values.
- R2: A binary add (`op_sel`=00, `bcd`=0) yields acc+operand+carry_in within the active width. C is bit 8 of the sum in 8-bit mode and bit 16 in 16-bit mode.
- R3: A binary subtract (`op_sel`=01, `bcd`=0) adds the operand inverted within the active width, plus carry_in. C=1 means no borrow.
- R4: A decimal add treats each 4-bit digit from the lowest upward. If digit sum plus incoming carry is 10 or more, the digit becomes (sum+6) mod 16 and a carry passes to the next digit. C is the carry out of the top active digit.
- R5: A decimal subtract starts with a borrow of 1−carry_in. For each digit, if acc digit − operand digit − borrow is negative, the digit becomes (difference−6) mod 16 and a borrow passes upward. C is the inverse of the final borrow.
- R6: In 8-bit mode only the two low digits, or the low byte, take part. Bits 15:8 of `acc_out` equal bits 15:8 of `acc_in`, and operand bits 15:8 are ignored.
- R7: For add and subtract, V=1 exactly when the accumulator and the effective operand have the same sign and the result's sign differs from it. The effective operand is the operand, inverted within the width for subtract. The sign is bit 7 or bit 15 according to width.
- R8: N is bit 7 or bit 15 of the result, and Z=1 when the active-width result is zero.
- R9: A compare (`op_sel`=1x) returns `acc_in` unchanged and V=0. Its C, N and Z come from the binary difference acc−operand within the width, with C=1 when acc ≥ operand. `carry_in` and `bcd` have no effect on a compare.
- R10: While `rst_n` is low, and directly after it is released, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| acc_in | input | 16 | Accumulator value |
| opnd_in | input | 16 | Operand value |
| carry_in | input | 1 | Carry flag input (not-borrow for subtract) |
| op_sel | input | 2 | 00 add, 01 subtract, 1x compare |
| wide | input | 1 | 1: 16-bit, 0: 8-bit |
| bcd | input | 1 | 1: decimal add/subtract |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| acc_out | output | 16 | New accumulator value |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
Directed operations cover the boundary cases: decimal 99+1 and 9999+1 rolling to zero with carry, 00−01 decimal wrapping to 99 with borrow, and signed overflow at both 7F+1 and 7FFF+1. They also cover 8-bit operations whose high byte and operand high byte are non-zero, and compares that come out equal, less and greater. Random operations with valid decimal digits mix the two widths, all operations and both carry values. Across these, binary and decimal results differ, so a wrong mode choice or a digit correction in the wrong place shows. A consumer that stalls at random exercises back-pressure, the holding of results and the timing of acceptance.

// File: rtl/bcdas_pkg.sv
package bcdas_pkg;
  localparam int unsigned DATA_W = 16;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_CMPX = 2'b11
  } op_e;

  function automatic logic is_compare(input logic [1:0] op);
    return op[1];
  endfunction

  function automatic logic is_subtract(input logic [1:0] op);
    return op[1] | op[0];
  endfunction
endpackage

// File: rtl/bcdas_decimal_chain.sv
module bcdas_decimal_chain #(
  parameter int unsigned DIGITS = 4,
  localparam int unsigned W = 4 * DIGITS
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic              cin,
  input  logic              sub,
  output logic [W-1:0]      sum,
  output logic [DIGITS-1:0] carry_vec
);
  // k carries the decimal carry (add) or the borrow (subtract) between digits
  logic [DIGITS:0] k;
  assign k[0] = sub ? ~cin : cin;

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [3:0] ad, bd, dig;
    logic [4:0] raw_add;
    logic [5:0] raw_sub;
    logic       fix_add, neg_sub;

    assign ad      = a[4*i +: 4];
    assign bd      = b[4*i +: 4];
    assign raw_add = {1'b0, ad} + {1'b0, bd} + {4'd0, k[i]};
    assign raw_sub = {2'b00, ad} - {2'b00, bd} - {5'd0, k[i]};
    assign fix_add = (raw_add >= 5'd10);
    assign neg_sub = raw_sub[5];

    always_comb begin
      if (sub) dig = neg_sub ? (raw_sub[3:0] - 4'd6) : raw_sub[3:0];
      else     dig = fix_add ? (raw_add[3:0] + 4'd6) : raw_add[3:0];
    end

    assign k[i+1]       = sub ? neg_sub : fix_add;
    assign sum[4*i +: 4] = dig;
    assign carry_vec[i] = sub ? ~neg_sub : fix_add;
  end
endmodule

// File: rtl/bcdas_binary_path.sv
module bcdas_binary_path #(
  parameter int unsigned W = 16,
  localparam int unsigned HALF = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic         cin,
  input  logic         wide,
  output logic [W-1:0] sum,
  output logic         carry
);
  logic [W:0] full;
  assign full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
  assign sum   = full[W-1:0];
  assign carry = wide ? full[W] : full[HALF];
endmodule

// File: rtl/bcdas_flag_unit.sv
module bcdas_flag_unit #(
  parameter int unsigned W = 16,
  localparam int unsigned HALF = W / 2
) (
  input  logic [W-1:0] res,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b_eff,
  input  logic         wide,
  output logic         neg,
  output logic         zero,
  output logic         ovf
);
  logic sr, sa, sb;
  assign sr   = wide ? res[W-1]   : res[HALF-1];
  assign sa   = wide ? a[W-1]     : a[HALF-1];
  assign sb   = wide ? b_eff[W-1] : b_eff[HALF-1];
  assign neg  = sr;
  assign zero = wide ? (res == '0) : (res[HALF-1:0] == '0);
  assign ovf  = (sa == sb) && (sr != sa);
endmodule

// File: rtl/bcd_addsub_unit.sv
module bcd_addsub_unit
  import bcdas_pkg::*;
#(
  parameter int unsigned W = DATA_W,
  localparam int unsigned HALF = W / 2,
  localparam int unsigned DIG  = W / 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opnd_in,
  input  logic         carry_in,
  input  logic [1:0]   op_sel,
  input  logic         wide,
  input  logic         bcd,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] acc_out,
  output logic         flag_n,
  output logic         flag_v,
  output logic         flag_z,
  output logic         flag_c
);
  logic [W-1:0] mask, a_m, b_m, b_eff, bin_sum, dec_sum, res_m, acc_nx;
  logic [DIG-1:0] dec_cv;
  logic cmp, sub, cin_eff, use_dec, bin_c, dec_c, c_nx, n_nx, z_nx, v_raw;

  assign cmp     = is_compare(op_sel);
  assign sub     = is_subtract(op_sel);
  assign mask    = wide ? {W{1'b1}} : {{HALF{1'b0}}, {HALF{1'b1}}};
  assign a_m     = acc_in & mask;
  assign b_m     = opnd_in & mask;
  assign b_eff   = sub ? (~opnd_in & mask) : b_m;
  assign cin_eff = cmp ? 1'b1 : carry_in;
  assign use_dec = bcd & ~cmp;

  bcdas_binary_path #(.W(W)) u_bin (
    .a(a_m), .b_eff(b_eff), .cin(cin_eff), .wide(wide),
    .sum(bin_sum), .carry(bin_c)
  );

  bcdas_decimal_chain #(.DIGITS(DIG)) u_dec (
    .a(a_m), .b(b_m), .cin(cin_eff), .sub(sub),
    .sum(dec_sum), .carry_vec(dec_cv)
  );

  assign dec_c = wide ? dec_cv[DIG-1] : dec_cv[DIG/2-1];
  assign res_m = (use_dec ? dec_sum : bin_sum) & mask;
  assign c_nx  = use_dec ? dec_c : bin_c;

  bcdas_flag_unit #(.W(W)) u_flg (
    .res(res_m), .a(a_m), .b_eff(b_eff), .wide(wide),
    .neg(n_nx), .zero(z_nx), .ovf(v_raw)
  );

  always_comb begin
    if (cmp)       acc_nx = acc_in;
    else if (wide) acc_nx = res_m;
    else           acc_nx = {acc_in[W-1:HALF], res_m[HALF-1:0]};
  end

  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      acc_out   <= '0;
      flag_n    <= 1'b0;
      flag_v    <= 1'b0;
      flag_z    <= 1'b0;
      flag_c    <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      acc_out   <= acc_nx;
      flag_n    <= n_nx;
      flag_v    <= v_raw & ~cmp;
      flag_z    <= z_nx;
      flag_c    <= c_nx;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/bcdas_checker.sv
module bcdas_checker #(
  parameter int unsigned W = 16,
  localparam int unsigned HALF = W / 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] acc_in,
  input logic [1:0]   op_sel,
  input logic         wide,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] acc_out,
  input logic         flag_v,
  input logic         flag_z,
  input logic         flag_c,
  input logic         flag_n
);
  a_r1_ready_rule: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));

  a_r1_accept_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r1_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(acc_out) && $stable(flag_c)
                                   && $stable(flag_z) && $stable(flag_n) && $stable(flag_v)));

  a_r6_high_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !wide) |=> (acc_out[W-1:HALF] == $past(acc_in[W-1:HALF])));

  a_r9_compare_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && op_sel[1]) |=> (acc_out == $past(acc_in) && !flag_v));

  a_r10_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

bind bcd_addsub_unit bcdas_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .acc_in(acc_in), .op_sel(op_sel), .wide(wide), .out_valid(out_valid),
  .out_ready(out_ready), .acc_out(acc_out), .flag_v(flag_v), .flag_z(flag_z),
  .flag_c(flag_c), .flag_n(flag_n)
);

// File: tb/bcd_addsub_unit_tb.sv
module bcd_addsub_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] acc_in = '0, opnd_in = '0;
  logic        carry_in = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic        wide = 1'b0, bcd = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] acc_out;
  logic        flag_n, flag_v, flag_z, flag_c;

  int n_vec = 0, n_bad = 0;
  bit stall_mode = 1'b0;
  string cur_tag = "R1";

  always #10 clk = ~clk;

  bcd_addsub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .acc_in(acc_in), .opnd_in(opnd_in), .carry_in(carry_in), .op_sel(op_sel),
    .wide(wide), .bcd(bcd), .out_valid(out_valid), .out_ready(out_ready),
    .acc_out(acc_out), .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z),
    .flag_c(flag_c)
  );

  // Behavioural reference: returns {acc, n, v, z, c}
  function automatic logic [19:0] ref_calc(input int a, input int b, input int c,
                                           input int op, input int w16, input int dec);
    int w, mask, am, bm, be, rm, r, k, s, cy, n, v, z, sa, sb, sr;
    w = w16 ? 16 : 8;
    mask = (1 << w) - 1;
    am = a & mask;
    bm = b & mask;
    if (op >= 2) begin
      s = am - bm;
      rm = s & mask;
      cy = (s >= 0) ? 1 : 0;
      n = (rm >> (w - 1)) & 1;
      z = (rm == 0) ? 1 : 0;
      return {a[15:0], n[0], 1'b0, z[0], cy[0]};
    end
    be = (op == 1) ? ((~bm) & mask) : bm;
    if (dec == 0) begin
      s = am + be + c;
      cy = (s >> w) & 1;
      rm = s & mask;
    end else if (op == 0) begin
      k = c; rm = 0;
      for (int i = 0; i < w / 4; i++) begin
        s = ((am >> (4 * i)) & 15) + ((bm >> (4 * i)) & 15) + k;
        if (s >= 10) begin s = (s + 6) & 15; k = 1; end else k = 0;
        rm = rm | (s << (4 * i));
      end
      cy = k;
    end else begin
      k = 1 - c; rm = 0;
      for (int i = 0; i < w / 4; i++) begin
        s = ((am >> (4 * i)) & 15) - ((bm >> (4 * i)) & 15) - k;
        if (s < 0) begin s = (s - 6) & 15; k = 1; end else k = 0;
        rm = rm | (s << (4 * i));
      end
      cy = 1 - k;
    end
    sa = (am >> (w - 1)) & 1;
    sb = (be >> (w - 1)) & 1;
    sr = (rm >> (w - 1)) & 1;
    v = (sa == sb && sr != sa) ? 1 : 0;
    n = sr;
    z = (rm == 0) ? 1 : 0;
    r = w16 ? rm : ((a & 16'hFF00) | rm);
    return {r[15:0], n[0], v[0], z[0], cy[0]};
  endfunction

  // Reference state, advanced on every rising edge
  logic        m_valid = 1'b0;
  logic [19:0] m_res = '0;
  string       m_tag = "R10";
  logic        m_rdy;
  assign m_rdy = !m_valid || out_ready;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
    end else if (in_valid && m_rdy) begin
      m_valid <= 1'b1;
      m_res   <= ref_calc(int'(acc_in), int'(opnd_in), int'(carry_in), int'(op_sel),
                          int'(wide), int'(bcd));
      m_tag   <= cur_tag;
    end else if (out_ready) begin
      m_valid <= 1'b0;
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    n_vec++;
    if (in_ready !== m_rdy || out_valid !== m_valid) begin
      n_bad++;
      $display("FAIL R1 R10 handshake: in_ready=%0b out_valid=%0b expected %0b %0b",
               in_ready, out_valid, m_rdy, m_valid);
    end else if (m_valid && acc_out !== m_res[19:4]) begin
      n_bad++;
      $display("FAIL %s acc: got %h expected %h", m_tag, acc_out, m_res[19:4]);
    end else if (m_valid && {flag_n, flag_v, flag_z, flag_c} !== m_res[3:0]) begin
      n_bad++;
      $display("FAIL %s flags R7 R8 NVZC: got %b expected %b", m_tag,
               {flag_n, flag_v, flag_z, flag_c}, m_res[3:0]);
    end
  end

  // Consumer, optionally stalling
  always @(posedge clk) begin
    #1 out_ready = stall_mode ? (($urandom % 4) != 0) : 1'b1;
  end

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c,
                       input logic [1:0] op, input logic w16, input logic dec, input string tag);
    bit taken;
    @(posedge clk); #2;
    acc_in = a; opnd_in = b; carry_in = c; op_sel = op; wide = w16; bcd = dec;
    cur_tag = tag; in_valid = 1'b1;
    do begin
      @(negedge clk); taken = in_ready;
      @(posedge clk);
    end while (!taken);
    #2 in_valid = 1'b0;
  endtask

  function automatic logic [15:0] rnd_bcd();
    logic [15:0] r;
    for (int i = 0; i < 4; i++) r[4*i +: 4] = 4'($urandom % 10);
    return r;
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #2 rst_n = 1'b1;
    // R10: out_valid idle is checked by the per-cycle compare
    repeat (2) @(posedge clk);
    apply(16'h1234, 16'h1111, 1'b0, 2'b00, 1'b1, 1'b0, "R2");
    apply(16'hFFFF, 16'h0001, 1'b0, 2'b00, 1'b1, 1'b0, "R2");
    apply(16'hAB7F, 16'hCD01, 1'b0, 2'b00, 1'b0, 1'b0, "R6");
    apply(16'h7FFF, 16'h0001, 1'b0, 2'b00, 1'b1, 1'b0, "R7");
    apply(16'h8000, 16'h0001, 1'b1, 2'b01, 1'b1, 1'b0, "R7");
    apply(16'h0010, 16'h0020, 1'b1, 2'b01, 1'b0, 1'b0, "R3");
    apply(16'h0000, 16'h0000, 1'b1, 2'b01, 1'b1, 1'b0, "R8");
    apply(16'h5599, 16'h7701, 1'b0, 2'b00, 1'b0, 1'b1, "R4");
    apply(16'h9999, 16'h0001, 1'b0, 2'b00, 1'b1, 1'b1, "R4");
    apply(16'h0458, 16'h0046, 1'b1, 2'b00, 1'b1, 1'b1, "R4");
    apply(16'h2200, 16'h3301, 1'b1, 2'b01, 1'b0, 1'b1, "R5");
    apply(16'h1000, 16'h0001, 1'b1, 2'b01, 1'b1, 1'b1, "R5");
    apply(16'h0050, 16'h0025, 1'b0, 2'b01, 1'b1, 1'b1, "R5");
    apply(16'h4242, 16'h4242, 1'b0, 2'b10, 1'b1, 1'b1, "R9");
    apply(16'h0010, 16'h0020, 1'b0, 2'b11, 1'b1, 1'b0, "R9");
    apply(16'hEE30, 16'h1120, 1'b0, 2'b10, 1'b0, 1'b1, "R9");
    stall_mode = 1'b1;
    for (int i = 0; i < 600; i++) begin
      logic [1:0] op;
      logic dec, w;
      logic [15:0] a, b;
      op  = 2'($urandom);
      dec = 1'($urandom);
      w   = 1'($urandom);
      a   = dec ? rnd_bcd() : 16'($urandom);
      b   = dec ? rnd_bcd() : 16'($urandom);
      if (!w) b[15:8] = 8'($urandom);
      apply(a, b, 1'($urandom), op, w, dec,
            op[1] ? "R9" : (dec ? (op[0] ? "R5" : "R4") : (op[0] ? "R3" : "R2")));
    end
    stall_mode = 1'b0;
    repeat (5) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL R1 watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule